// File: doc/BRIEF.md
# Multidrop UART with Address Marking

This block is a serial port with a small register bus, meant for shared RS485-style lines where one master talks to many stations. Every frame carries a ninth bit. Ordinary data bytes go out with odd parity. A byte sent while the line-control "address select" bit is set goes out with even parity instead. On the receive side, a byte whose parity fails the odd check is taken as an address mark, not as a parity error.

Software arms the address select and writes the station byte. When the transmitter finishes a frame with parity on, it clears the select bit by itself, so the rest of the message needs no further writes to line control. The transmit path holds 16 bytes, or one byte when the queue is switched off. The receive path always queues up to 16 bytes. A fixed clock divider makes the 16x oversampling tick. One interrupt line reports the highest-priority pending cause.

Register map (3-bit address):
- 0: transmit holding (write) and receive buffer (read, pops one byte).
- 1: interrupt enable (write) and interrupt identification (read).
- 2: queue control (bit 0).
- 3: line control.
- 5: line status.

Top module: `mdrop_uart`

## Requirements
- R1: After reset, line status reads 0x60, interrupt identification reads 0x01, `txd` is high and `irq` is low.
- R2: A transmitted frame has these bits in order:
  - a low start bit;
  - 8 data bits, LSB first;
  - a parity bit, only when line-control bit 3 is set;
  - a high stop bit.

  Each bit lasts 16*CLK_DIV clocks. When line-control bit 4 is 1 the parity bit is the XOR of the data (even parity). When bit 4 is 0 it is its inverse (odd parity).
- R3: At the end of every frame sent with line-control bit 3 set, line-control bit 4 is cleared by hardware. This includes a set that software made while that frame was still being shifted out.
- R4: Line-status bit 5 is 1 while the transmit queue holds fewer bytes than its capacity. The capacity is 16 when queue-control bit 0 is 1 and 1 when it is 0. Writes beyond capacity are dropped. Line-status bit 6 is 1 only when the queue is empty and the shifter is idle.
- R5: The receiver is always hunting for a start bit. It samples mid-bit, takes 8 data bits LSB first, then a parity bit when line-control bit 3 is set, then the stop bit. The byte then appears at address 0 with line-status bit 0 set.
- R6: With parity enabled, a received byte whose data plus parity holds an even count of ones sets line-status bit 2 (address mark). No parity error is reported.
- R7: A low stop bit sets line-status bit 3 (framing error).
- R8: A low pulse on `rxd` shorter than half a bit does not produce a byte.
- R9: Interrupt identification reads {4'b0, code, none}. The `none` bit is 1 when no enabled cause is pending. The codes, in priority order, are:
  - line status: 3'b011, enabled by enable bit 2;
  - receive data: 3'b010, enabled by enable bit 0;
  - transmit empty: 3'b001, enabled by enable bit 1.

  `irq` is high whenever an enabled cause is pending.
- R10: The transmit-empty cause is raised when the shifter takes the last queued byte. It is cleared by a write to address 0.
- R11: Reading line status clears bits 2 and 3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | 3 | Register address |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (side effects) |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` (combinational) |
| txd | output | 1 | Serial output, idles high |
| rxd | input | 1 | Serial input |
| irq | output | 1 | Interrupt request |

## Verification
The assertions check the following on every cycle:
- the line idles high whenever the shifter is idle;
- a frame opens with a low level;
- the address select is gone the cycle after a frame with parity completes;
- a write to address 0 withdraws the transmit-empty cause;
- transmit-empty status always accompanies idle status;
- neither queue ever holds more than its depth.

Only the bench scenarios can show the rest:
- the actual parity value on the wire;
- the clear of a late address-select write;
- the classification of received bytes as data, address or framing error;
- rejection of a short glitch;
- the exact priority order seen through interrupt identification as causes are removed one by one.

// File: rtl/mdu_pkg.sv
package mdu_pkg;
  localparam logic [2:0] A_DATA = 3'd0;
  localparam logic [2:0] A_INT  = 3'd1;
  localparam logic [2:0] A_QCTL = 3'd2;
  localparam logic [2:0] A_LINE = 3'd3;
  localparam logic [2:0] A_STAT = 3'd5;

  localparam logic [2:0] IC_LINE = 3'b011;
  localparam logic [2:0] IC_RXD  = 3'b010;
  localparam logic [2:0] IC_TXE  = 3'b001;
  localparam logic [2:0] IC_NONE = 3'b000;

  // parity bit for a byte: even selects XOR, odd selects its inverse
  function automatic logic par_bit(input logic [7:0] d, input logic even);
    return even ? ^d : ~^d;
  endfunction

  // true when data plus parity bit fails the odd check
  function automatic logic is_mark(input logic [7:0] d, input logic p);
    return ~(^d ^ p);
  endfunction
endpackage

// File: rtl/mdu_tick.sv
module mdu_tick #(
  parameter int DIV = 27
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  logic [CW-1:0] cnt;

  assign tick = (cnt == CW'(DIV - 1));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) cnt <= '0;
    else if (tick) cnt <= '0;
    else cnt <= cnt + 1'b1;
endmodule

// File: rtl/mdu_fifo.sv
module mdu_fifo #(
  parameter int W = 8,
  parameter int DEPTH = 16,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] cap,
  input  logic          push,
  input  logic [W-1:0]  din,
  input  logic          pop,
  output logic [W-1:0]  dout,
  output logic [CW-1:0] count,
  output logic          empty
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic          do_push, do_pop;

  assign empty   = (count == '0);
  assign do_push = push && (count < cap) && (count < CW'(DEPTH));
  assign do_pop  = pop && !empty;
  assign dout    = mem[rptr];

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) if (do_push) mem[wptr] <= din;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      wptr <= '0; rptr <= '0; count <= '0;
    end else begin
      if (do_push) wptr <= nxt(wptr);
      if (do_pop)  rptr <= nxt(rptr);
      count <= count + CW'(do_push) - CW'(do_pop);
    end

  // R4
  fifo_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));
endmodule

// File: rtl/mdu_tx.sv
module mdu_tx
  import mdu_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       avail,
  input  logic [7:0] data,
  input  logic       pen,
  input  logic       eps,
  output logic       load,
  output logic       txd,
  output logic       busy,
  output logic       done
);
  logic [10:0] frame;
  logic [3:0]  tcnt, bitn, last;

  assign load = !busy && avail;
  assign txd  = busy ? frame[0] : 1'b1;
  assign done = busy && tick && (tcnt == 4'd15) && (bitn == last);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      frame <= '1; tcnt <= '0; bitn <= '0; last <= '0; busy <= 1'b0;
    end else if (load) begin
      frame <= {1'b1, pen ? par_bit(data, eps) : 1'b1, data, 1'b0};
      last  <= pen ? 4'd10 : 4'd9;
      tcnt  <= '0;
      bitn  <= '0;
      busy  <= 1'b1;
    end else if (busy && tick) begin
      tcnt <= tcnt + 1'b1;
      if (tcnt == 4'd15) begin
        frame <= {1'b1, frame[10:1]};
        if (bitn == last) busy <= 1'b0;
        else bitn <= bitn + 1'b1;
      end
    end

  // R2
  txd_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> txd);
  // R2
  start_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !txd);
endmodule

// File: rtl/mdu_rx.sv
module mdu_rx
  import mdu_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       rxd,
  input  logic       pen,
  output logic       push,
  output logic [7:0] pdata,
  output logic       mark,
  output logic       ferr
);
  logic       rs1, rs2, armed, active, par;
  logic [3:0] tcnt, bitn;
  logic [7:0] sh;
  logic       at_stop;

  assign at_stop = pen ? (bitn == 4'd10) : (bitn == 4'd9);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rs1 <= 1'b1; rs2 <= 1'b1; armed <= 1'b0; active <= 1'b0; par <= 1'b0;
      tcnt <= '0; bitn <= '0; sh <= '0;
      push <= 1'b0; pdata <= '0; mark <= 1'b0; ferr <= 1'b0;
    end else begin
      rs1  <= rxd;
      rs2  <= rs1;
      push <= 1'b0;
      if (tick) begin
        if (!active) begin
          if (rs2) armed <= 1'b1;
          else if (armed) begin
            active <= 1'b1; armed <= 1'b0; tcnt <= '0; bitn <= '0;
          end
        end else begin
          tcnt <= tcnt + 1'b1;
          if (tcnt == 4'd7) begin
            if (bitn == 4'd0) begin
              if (rs2) active <= 1'b0;
              else bitn <= 4'd1;
            end else if (at_stop) begin
              push   <= 1'b1;
              pdata  <= sh;
              mark   <= pen && is_mark(sh, par);
              ferr   <= !rs2;
              active <= 1'b0;
            end else if (bitn == 4'd9) begin
              par  <= rs2;
              bitn <= bitn + 1'b1;
            end else begin
              sh   <= {rs2, sh[7:1]};
              bitn <= bitn + 1'b1;
            end
          end
        end
      end
    end

  // R5
  push_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !active);
endmodule

// File: rtl/mdrop_uart.sv
module mdrop_uart
  import mdu_pkg::*;
#(
  parameter int CLK_DIV    = 27,
  parameter int FIFO_DEPTH = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] addr,
  input  logic       wr_en,
  input  logic       rd_en,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  output logic       txd,
  input  logic       rxd,
  output logic       irq
);
  localparam int CW = $clog2(FIFO_DEPTH + 1);

  logic          tick, fifo_en, thre_pend, st_mark, st_ferr;
  logic [7:0]    lcr;
  logic [2:0]    ier;
  logic [CW-1:0] tx_cap, tx_cnt, rx_cnt;
  logic [7:0]    tx_dout, rx_dout, rx_pdata;
  logic          tx_empty, tx_load, tx_busy, tx_done, rx_empty;
  logic          rx_push, rx_mark, rx_ferr;
  logic          wr_thr, wr_lcr, rd_rbr, rd_lsr;
  logic          thre, temt, pend_line, pend_rx, pend_tx, pend;
  logic [2:0]    code;
  logic [7:0]    lsr, iir;

  assign wr_thr = wr_en && (addr == A_DATA);
  assign wr_lcr = wr_en && (addr == A_LINE);
  assign rd_rbr = rd_en && (addr == A_DATA);
  assign rd_lsr = rd_en && (addr == A_STAT);
  assign tx_cap = fifo_en ? CW'(FIFO_DEPTH) : CW'(1);

  mdu_tick #(.DIV(CLK_DIV)) u_tick (.clk(clk), .rst_n(rst_n), .tick(tick));

  mdu_fifo #(.W(8), .DEPTH(FIFO_DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_n), .cap(tx_cap), .push(wr_thr), .din(wdata),
    .pop(tx_load), .dout(tx_dout), .count(tx_cnt), .empty(tx_empty));

  mdu_tx u_tx (
    .clk(clk), .rst_n(rst_n), .tick(tick), .avail(!tx_empty), .data(tx_dout),
    .pen(lcr[3]), .eps(lcr[4]), .load(tx_load), .txd(txd), .busy(tx_busy),
    .done(tx_done));

  mdu_rx u_rx (
    .clk(clk), .rst_n(rst_n), .tick(tick), .rxd(rxd), .pen(lcr[3]),
    .push(rx_push), .pdata(rx_pdata), .mark(rx_mark), .ferr(rx_ferr));

  mdu_fifo #(.W(8), .DEPTH(FIFO_DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_n), .cap(CW'(FIFO_DEPTH)), .push(rx_push),
    .din(rx_pdata), .pop(rd_rbr), .dout(rx_dout), .count(rx_cnt),
    .empty(rx_empty));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      lcr <= '0; ier <= '0; fifo_en <= 1'b0;
      thre_pend <= 1'b0; st_mark <= 1'b0; st_ferr <= 1'b0;
    end else begin
      if (wr_lcr) lcr <= wdata;
      else if (tx_done && lcr[3]) lcr[4] <= 1'b0;
      if (wr_en && addr == A_INT)  ier <= wdata[2:0];
      if (wr_en && addr == A_QCTL) fifo_en <= wdata[0];
      if (wr_thr) thre_pend <= 1'b0;
      else if (tx_load && tx_cnt == CW'(1)) thre_pend <= 1'b1;
      if (rx_push && rx_mark) st_mark <= 1'b1;
      else if (rd_lsr) st_mark <= 1'b0;
      if (rx_push && rx_ferr) st_ferr <= 1'b1;
      else if (rd_lsr) st_ferr <= 1'b0;
    end

  assign thre = tx_cnt < tx_cap;
  assign temt = tx_empty && !tx_busy;
  assign lsr  = {1'b0, temt, thre, 1'b0, st_ferr, st_mark, 1'b0, !rx_empty};

  assign pend_line = ier[2] && (st_mark || st_ferr);
  assign pend_rx   = ier[0] && !rx_empty;
  assign pend_tx   = ier[1] && thre_pend;
  assign pend      = pend_line || pend_rx || pend_tx;
  assign code      = pend_line ? IC_LINE : pend_rx ? IC_RXD : pend_tx ? IC_TXE : IC_NONE;
  assign iir       = {4'b0, code, !pend};
  assign irq       = pend;

  always_comb
    case (addr)
      A_DATA:  rdata = rx_dout;
      A_INT:   rdata = iir;
      A_QCTL:  rdata = {7'b0, fifo_en};
      A_LINE:  rdata = lcr;
      A_STAT:  rdata = lsr;
      default: rdata = 8'h00;
    endcase

  // R3
  eps_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_done && lcr[3] && !wr_lcr) |=> !lcr[4]);
  // R10
  thr_write_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_thr |=> !thre_pend);
  // R4
  temt_thre_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lsr[6] |-> lsr[5]);
  // R5
  rx_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_cnt <= CW'(FIFO_DEPTH));
endmodule

// File: tb/mdrop_uart_test.sv
module mdrop_uart_test;
  localparam int DIV = 2;
  localparam int BITC = 16 * DIV;

  logic       clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, rd_en = 1'b0, rxd = 1'b1;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0, rdata;
  logic       txd, irq;
  int         total = 0, fails = 0;
  logic [7:0] rv;

  always #5 clk = ~clk;

  mdrop_uart #(.CLK_DIV(DIV), .FIFO_DEPTH(16)) uut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .rdata(rdata), .txd(txd), .rxd(rxd), .irq(irq));

  // {data, parity bit, stop bit, expected mark, expected framing error}
  localparam logic [11:0] RXV [0:5] = '{12'h55C, 12'h556, 12'h014,
                                        12'hFFC, 12'h801, 12'h006};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd_en = 1'b1; #1 d = rdata;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic send(input logic [7:0] d, input logic p, input logic s, input logic pen);
    @(negedge clk);
    rxd = 1'b0; repeat (BITC) @(negedge clk);
    for (int i = 0; i < 8; i++) begin rxd = d[i]; repeat (BITC) @(negedge clk); end
    if (pen) begin rxd = p; repeat (BITC) @(negedge clk); end
    rxd = s; repeat (BITC) @(negedge clk);
    rxd = 1'b1; repeat (BITC) @(negedge clk);
  endtask

  task automatic grab(input logic pen, output logic [7:0] d, output logic p, output logic s);
    int n = 0;
    while (txd && n < 20000) begin @(negedge clk); n++; end
    repeat (BITC / 2) @(negedge clk);
    for (int i = 0; i < 8; i++) begin repeat (BITC) @(negedge clk); d[i] = txd; end
    p = 1'b1;
    if (pen) begin repeat (BITC) @(negedge clk); p = txd; end
    repeat (BITC) @(negedge clk); s = txd;
  endtask

  task automatic wait_idle();
    logic [7:0] v;
    for (int i = 0; i < 2000; i++) begin
      rd(3'd5, v);
      if (v[6]) break;
      repeat (8) @(negedge clk);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++; total++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    logic [7:0] d; logic p, s;
    repeat (3) @(negedge clk);
    #1; chk("R1 txd", txd, 1); chk("R1 irq", irq, 0);
    rst_n = 1'b1;
    rd(3'd5, rv); chk("R1 lsr", rv, 8'h60);
    rd(3'd1, rv); chk("R1 iir", rv, 8'h01);

    // receive table, parity on (line control bit 3)
    wr(3'd3, 8'h08);
    for (int k = 0; k < 6; k++) begin
      send(RXV[k][11:4], RXV[k][3], RXV[k][2], 1'b1);
      rd(3'd5, rv);
      chk("R5 R6 R7 lsr", rv, 8'h61 | {4'b0, RXV[k][0], RXV[k][1], 2'b0});
      rd(3'd0, rv); chk("R5 data", rv, RXV[k][11:4]);
      rd(3'd5, rv); chk("R11 lsr clear", rv, 8'h60);
    end

    // R2 R3 address byte with even parity, then select cleared
    wr(3'd3, 8'h18); wr(3'd0, 8'hA5);
    grab(1'b1, d, p, s);
    chk("R2 addr data", d, 8'hA5); chk("R2 even parity", p, 0); chk("R2 stop", s, 1);
    wait_idle();
    rd(3'd3, rv); chk("R3 auto clear", rv, 8'h08);

    // R3 late set while a data byte is on the wire
    wr(3'd0, 8'h03);
    fork
      grab(1'b1, d, p, s);
      begin repeat (100) @(negedge clk); wr(3'd3, 8'h18); end
    join
    chk("R2 odd parity", p, 1);
    wait_idle();
    rd(3'd3, rv); chk("R3 late set cleared", rv, 8'h08);

    // R4 single-entry holding
    wr(3'd2, 8'h00);
    wr(3'd0, 8'h11); wr(3'd0, 8'h22); wr(3'd0, 8'h33);
    rd(3'd5, rv); chk("R4 full single", rv, 8'h00);
    grab(1'b1, d, p, s); chk("R4 first", d, 8'h11);
    grab(1'b1, d, p, s); chk("R4 second", d, 8'h22);
    repeat (BITC) @(negedge clk);
    rd(3'd5, rv); chk("R4 third dropped", rv, 8'h60);

    // R4 sixteen-entry queue
    wr(3'd2, 8'h01);
    for (int i = 0; i < 16; i++) wr(3'd0, 8'(i));
    rd(3'd5, rv); chk("R4 room at 15", rv, 8'h20);
    wr(3'd0, 8'h77);
    rd(3'd5, rv); chk("R4 full 16", rv, 8'h00);
    wait_idle();

    // R10 transmit-empty cause
    wr(3'd1, 8'h02);
    #1 chk("R10 irq raised", irq, 1);
    rd(3'd1, rv); chk("R9 iir txe", rv, 8'h02);
    wr(3'd0, 8'h44); wr(3'd0, 8'h45);
    repeat (4) @(negedge clk);
    chk("R10 irq cleared", irq, 0);
    rd(3'd1, rv); chk("R9 iir none", rv, 8'h01);
    wait_idle();
    #1 chk("R10 irq again", irq, 1);

    // R9 priority
    wr(3'd1, 8'h07);
    send(8'h55, 1'b0, 1'b1, 1'b1);
    rd(3'd1, rv); chk("R9 line first", rv, 8'h06);
    rd(3'd5, rv); chk("R6 mark status", rv, 8'h65);
    rd(3'd1, rv); chk("R9 rx second", rv, 8'h04);
    rd(3'd0, rv); chk("R5 mark byte", rv, 8'h55);
    rd(3'd1, rv); chk("R9 txe third", rv, 8'h02);
    wr(3'd1, 8'h00);

    // parity off
    wr(3'd3, 8'h00);
    send(8'h3C, 1'b0, 1'b1, 1'b0);
    rd(3'd5, rv); chk("R5 no parity lsr", rv, 8'h61);
    rd(3'd0, rv); chk("R5 no parity data", rv, 8'h3C);
    wr(3'd0, 8'h81);
    grab(1'b0, d, p, s);
    chk("R2 no parity data", d, 8'h81); chk("R2 no parity stop", s, 1);
    wait_idle();

    // R8 short glitch
    @(negedge clk); rxd = 1'b0; repeat (BITC / 4) @(negedge clk); rxd = 1'b1;
    repeat (3 * BITC) @(negedge clk);
    rd(3'd5, rv); chk("R8 glitch ignored", rv, 8'h60);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule